// File: doc/BRIEF.md
# DMA Request Channel Router

This block sits between the peripheral request lines of a chip and the request inputs of a DMA engine. There are 64 request slots. Each of 16 output channels holds a one-byte configuration. The byte picks one slot, turns the channel on, and can place the channel in a periodic mode. In periodic mode, a rising edge on that channel's trigger input lets exactly one request through. Slots 62 and 63 have no peripheral behind them and always count as requesting. A periodic channel that selects one of them therefore issues one request per trigger.

Software reaches the configuration bytes through a byte-wide register port. Channel n sits at byte address n. Reads return the data one cycle after the read strobe. While a channel is on, its slot and mode fields are frozen and only the enable bit can change. Each channel output is a register, so a request shows up one clock after the slot input that caused it.

Top module: `dreq_router`

## Requirements
- R1: Channel n's configuration byte sits at byte address n for n = 0..15. Bits [5:0] hold the slot number, bit 6 is the periodic-mode flag and bit 7 is the channel enable. Whatever is written to a disabled channel reads back unchanged.
- R2: After reset every configuration byte reads 0x00 and every channel output is 0.
- R3: Read data appears on reg_rdata on the clock edge that samples reg_rd_en high. While reg_rd_en is low, reg_rdata holds its last value, even when a register is written.
- R4: A channel whose enable bit is 0 drives 0 on its output, whatever its slot, flag and trigger inputs are.
- R5: A channel that is enabled and not periodic drives, one clock later, the value of the slot_req bit its slot field selects.
- R6: Slots 62 and 63 count as permanently requesting, whatever their slot_req inputs carry.
- R7: A periodic channel is armed by a rising edge on its chan_trig bit. In the first cycle that is armed (the edge cycle included) and has its selected slot requesting, it produces a one-cycle request and disarms. Further requests need a new edge.
- R8: A write to a channel whose enable bit is 1 updates only bit 7. Bits [6:0] keep their stored value.
- R9: Clearing a channel's enable bit discards its armed state. After re-enabling, the channel produces no request until a new trigger edge arrives.
- R10: Addresses 16 to 255 read as 0x00, and writes to them change no configuration byte.
- R11: A trigger input held high arms a channel only once, on its rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, registered |
| slot_req | input | 64 | Peripheral request slots |
| chan_trig | input | 16 | Per-channel periodic trigger |
| chan_req | output | 16 | Per-channel request to the DMA engine |

## Verification
The bench steps every channel through all 64 slots, with the selected slot driven alone and then with every other slot driven. A router that decoded the slot field wrongly, or that forgot the two always-on slots, would show a request on the wrong channel or lose one. It writes to channels while they are enabled and to addresses past the last channel. A design that let a frozen field change, or that aliased high addresses onto low ones, would then route a different slot or read back a changed byte. Trigger sequences cover an arm that comes before the slot, a trigger held high for several cycles, and a disable/enable cycle while armed. These expose a design that repeats requests, treats a trigger level as an edge, or keeps a stale armed state.

// File: rtl/dreq_router_pkg.sv
package dreq_router_pkg;

  localparam int SLOT_W    = 6;
  localparam int NUM_SLOTS = 1 << SLOT_W;
  localparam int CFG_W     = SLOT_W + 2;

  // Field order matters: software decodes enable at the top bit, flag below it.
  typedef struct packed {
    logic              en;
    logic              per;
    logic [SLOT_W-1:0] slot;
  } dreq_cfg_t;

  // Byte write rule: an enabled channel accepts only a new enable bit.
  function automatic dreq_cfg_t cfg_merge(dreq_cfg_t cur, logic [CFG_W-1:0] wdata);
    dreq_cfg_t nxt;
    nxt = dreq_cfg_t'(wdata);
    if (cur.en) begin
      nxt.per  = cur.per;
      nxt.slot = cur.slot;
    end
    return nxt;
  endfunction

  // A slot is forced on when it lies among the top aon_cnt numbers.
  function automatic logic slot_forced(int unsigned idx, int unsigned n_slots,
                                       int unsigned aon_cnt);
    return (idx + aon_cnt >= n_slots);
  endfunction

  // Next armed state of one periodic channel.
  function automatic logic arm_next(logic en, logic per, logic armed,
                                    logic rise, logic fire);
    if (!en || !per) return 1'b0;
    if (fire)        return 1'b0;
    if (rise)        return 1'b1;
    return armed;
  endfunction

endpackage

// File: rtl/dreq_slot_view.sv
module dreq_slot_view
  import dreq_router_pkg::*;
#(
  parameter int AON_COUNT = 2
) (
  input  logic [NUM_SLOTS-1:0] raw_i,
  output logic [NUM_SLOTS-1:0] eff_o
);

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    localparam logic FORCED = slot_forced(s, NUM_SLOTS, AON_COUNT);
    assign eff_o[s] = raw_i[s] | FORCED;
  end

endmodule

// File: rtl/dreq_cfg_bank.sv
module dreq_cfg_bank
  import dreq_router_pkg::*;
#(
  parameter int NUM_CH = 16,
  parameter int ADDR_W = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic                   rd_en,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [CFG_W-1:0]       wdata,
  output logic [CFG_W-1:0]       rdata,
  output dreq_cfg_t [NUM_CH-1:0] cfg_o
);

  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  dreq_cfg_t [NUM_CH-1:0] cfg_q;
  logic                   addr_hit;
  logic [IDX_W-1:0]       idx;
  logic [NUM_CH-1:0]      wr_sel;

  assign addr_hit = (addr < ADDR_W'(NUM_CH));
  assign idx      = addr[IDX_W-1:0];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_sel
    assign wr_sel[c] = wr_en && addr_hit && (idx == IDX_W'(c));

    // Frozen fields of an enabled channel stay put across any write.
    assert_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_q[c].en |=> ({cfg_q[c].per, cfg_q[c].slot} ==
                       $past({cfg_q[c].per, cfg_q[c].slot})));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (wr_sel[c]) cfg_q[c] <= cfg_merge(cfg_q[c], wdata);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= addr_hit ? CFG_W'(cfg_q[idx]) : '0;
  end

  assign cfg_o = cfg_q;

  assert_oob_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !addr_hit) |=> (rdata == '0));

  assert_oob_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr_hit) |=> $stable(cfg_q));

  assert_rd_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));

endmodule

// File: rtl/dreq_chan_path.sv
module dreq_chan_path
  import dreq_router_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  dreq_cfg_t            cfg_i,
  input  logic [NUM_SLOTS-1:0] slot_vec,
  input  logic                 trig_i,
  output logic                 req_o
);

  logic trig_q;
  logic armed_q;
  logic src_sel;
  logic trig_rise;
  logic arm_live;
  logic periodic;
  logic fire_now;
  logic pass_now;

  assign src_sel   = slot_vec[cfg_i.slot];
  assign trig_rise = trig_i & ~trig_q;
  assign arm_live  = armed_q | trig_rise;
  assign periodic  = cfg_i.en & cfg_i.per;
  assign fire_now  = periodic & arm_live & src_sel;
  assign pass_now  = cfg_i.en & ~cfg_i.per & src_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q  <= 1'b0;
      armed_q <= 1'b0;
      req_o   <= 1'b0;
    end else begin
      trig_q  <= trig_i;
      armed_q <= arm_next(cfg_i.en, cfg_i.per, armed_q, trig_rise, fire_now);
      req_o   <= fire_now | pass_now;
    end
  end

  assert_off_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_i.en |=> !req_o);

  assert_normal_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_i.en && !cfg_i.per) |=> (req_o == $past(src_sel)));

  assert_single_shot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (periodic && req_o) |=> !req_o);

  assert_disarm_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_i.en |=> !armed_q);

  assert_level_once_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (periodic && trig_q && !armed_q) |-> !fire_now);

endmodule

// File: rtl/dreq_router.sv
module dreq_router
  import dreq_router_pkg::*;
#(
  parameter int NUM_CH    = 16,
  parameter int ADDR_W    = 8,
  parameter int AON_COUNT = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr_en,
  input  logic                 reg_rd_en,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [CFG_W-1:0]     reg_wdata,
  output logic [CFG_W-1:0]     reg_rdata,
  input  logic [NUM_SLOTS-1:0] slot_req,
  input  logic [NUM_CH-1:0]    chan_trig,
  output logic [NUM_CH-1:0]    chan_req
);

  dreq_cfg_t [NUM_CH-1:0] cfg_all;
  logic [NUM_SLOTS-1:0]   slot_eff;

  dreq_cfg_bank #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_bank (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (reg_wr_en),
    .rd_en (reg_rd_en),
    .addr  (reg_addr),
    .wdata (reg_wdata),
    .rdata (reg_rdata),
    .cfg_o (cfg_all)
  );

  dreq_slot_view #(.AON_COUNT(AON_COUNT)) u_view (
    .raw_i (slot_req),
    .eff_o (slot_eff)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    dreq_chan_path u_path (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_i    (cfg_all[c]),
      .slot_vec (slot_eff),
      .trig_i   (chan_trig[c]),
      .req_o    (chan_req[c])
    );
  end

endmodule

// File: tb/dreq_router_tb.sv
module dreq_router_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic        reg_rd_en = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic [63:0] slot_req = '0;
  logic [15:0] chan_trig = '0;
  logic [15:0] chan_req;

  int n_chk = 0;
  int n_bad = 0;
  logic [7:0] model [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  dreq_router u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .slot_req(slot_req), .chan_trig(chan_trig), .chan_req(chan_req)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = 8'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
    if (a < 16) model[a] = model[a][7] ? {d[7], model[a][6:0]} : d;
  endtask

  task automatic rd(input int a, output logic [7:0] v);
    @(negedge clk);
    reg_rd_en = 1'b1; reg_addr = 8'(a);
    @(negedge clk);
    reg_rd_en = 1'b0;
    v = reg_rdata;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    logic [7:0] held;
    int cnt;
    for (int i = 0; i < 16; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R2: reset state
    chk("R2 outputs", 64'(chan_req), 64'h0);
    for (int i = 0; i < 16; i++) begin rd(i, v); chk("R2 reg", 64'(v), 64'h0); end

    // R1: layout and readback on disabled channels
    for (int i = 0; i < 16; i++) wr(i, {1'b0, 1'(i), 6'(i * 3 + 1)});
    for (int i = 0; i < 16; i++) begin rd(i, v); chk("R1 readback", 64'(v), 64'(model[i])); end

    // R3: read data holds without a read strobe
    rd(1, held);
    wr(1, 8'h3E);
    chk("R3 hold", 64'(reg_rdata), 64'(held));
    rd(1, v);
    chk("R3 new read", 64'(v), 64'h3E);

    // R10: high addresses read zero, writes go nowhere
    wr(16, 8'hFF); wr(200, 8'hFF); wr(255, 8'hAB);
    rd(16, v);  chk("R10 read 16", 64'(v), 64'h0);
    rd(255, v); chk("R10 read 255", 64'(v), 64'h0);
    for (int i = 0; i < 16; i++) begin rd(i, v); chk("R10 no alias", 64'(v), 64'(model[i])); end
    slot_req = '1;
    @(negedge clk);
    chk("R10/R4 all off", 64'(chan_req), 64'h0);

    // R5/R6/R4: every channel across every slot
    for (int i = 0; i < 16; i++) wr(i, 8'h00);
    for (int ch = 0; ch < 16; ch++) begin
      for (int s = 0; s < 64; s++) begin
        wr(ch, 8'h80 | 8'(s));
        slot_req = 64'd1 << s;
        @(negedge clk);
        chk("R5 route", 64'(chan_req), 64'(16'd1 << ch));
        slot_req = ~(64'd1 << s);
        @(negedge clk);
        chk((s >= 62) ? "R6 always on" : "R5 isolate", 64'(chan_req),
            (s >= 62) ? 64'(16'd1 << ch) : 64'h0);
        wr(ch, 8'h00);
        slot_req = '1;
        @(negedge clk);
        chk("R4 disabled", 64'(chan_req), 64'h0);
      end
    end
    slot_req = '0;

    // R8: enabled channel keeps slot and flag
    wr(3, 8'h85);
    wr(3, 8'hC9);
    rd(3, v); chk("R8 frozen", 64'(v), 64'h85);
    slot_req = 64'd1 << 5;
    @(negedge clk); chk("R8 old slot", 64'(chan_req[3]), 64'h1);
    slot_req = 64'd1 << 9;
    @(negedge clk); chk("R8 new slot ignored", 64'(chan_req[3]), 64'h0);
    wr(3, 8'h09);
    rd(3, v); chk("R8 only enable", 64'(v), 64'h05);
    slot_req = '0;

    // R7: arm before slot, single shot
    wr(2, 8'hCA);
    @(negedge clk); chk("R7 idle", 64'(chan_req[2]), 64'h0);
    chan_trig[2] = 1'b1;
    @(negedge clk); chk("R7 armed no slot", 64'(chan_req[2]), 64'h0);
    chan_trig[2] = 1'b0;
    slot_req[10] = 1'b1;
    @(negedge clk); chk("R7 fire", 64'(chan_req[2]), 64'h1);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); chk("R7 disarmed", 64'(chan_req[2]), 64'h0);
    end
    // R11: held trigger fires once
    chan_trig[2] = 1'b1;
    @(negedge clk); chk("R11 edge fire", 64'(chan_req[2]), 64'h1);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); chk("R11 level held", 64'(chan_req[2]), 64'h0);
    end
    chan_trig[2] = 1'b0;
    @(negedge clk); chk("R11 release", 64'(chan_req[2]), 64'h0);
    wr(2, 8'h4A);
    slot_req = '0;

    // R6 with R7: always-on slot gives one request per trigger
    wr(4, 8'hC0 | 8'd62);
    cnt = 0;
    for (int cyc = 0; cyc < 30; cyc++) begin
      chan_trig[4] = (cyc % 10 == 0);
      @(negedge clk);
      cnt += int'(chan_req[4]);
    end
    chan_trig[4] = 1'b0;
    chk("R6 per-trigger count", 64'(cnt), 64'd3);
    wr(4, 8'h00);

    // R9: disable drops the armed state
    wr(5, 8'hC0 | 8'd20);
    chan_trig[5] = 1'b1;
    @(negedge clk);
    chan_trig[5] = 1'b0;
    wr(5, 8'h54);
    wr(5, 8'hD4);
    rd(5, v); chk("R9 reenabled", 64'(v), 64'hD4);
    slot_req[20] = 1'b1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk); chk("R9 stale arm", 64'(chan_req[5]), 64'h0);
    end
    chan_trig[5] = 1'b1;
    @(negedge clk); chk("R9 new trigger", 64'(chan_req[5]), 64'h1);
    chan_trig[5] = 1'b0;
    wr(5, 8'h00);
    slot_req = '0;

    finish_run();
  end
endmodule